// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. One 64-bit main counter advances by one each clock while the unit is enabled. Three comparator channels watch that counter, and each channel drives one interrupt output. Software programs the unit through a 32-bit register port. Each register access carries an address, a size code and, for a write, the data. Read data comes back registered.

Each channel runs in one-shot or periodic mode and signals by level or by edge. The first time software writes a comparator, that value is also kept as the channel's period. In periodic mode the channel adds that period back onto its comparator every time it fires, so it fires again one period later. A level-mode channel raises a bit in a shared status register, and software clears that bit by writing one to it. An edge-mode channel gives a pulse one clock wide and never touches the status register.

The per-channel message value and message address words are plain storage and drive nothing.

Top module: `evt_timer_unit`

## Requirements
- R1: After reset the main counter, the global configuration, the status register, every channel configuration and every interrupt output are 0. Every comparator is all ones.
- R2: Offset 0x000 reads the capability word: revision in bits 7:0, channel count minus one in bits 12:8, 1 in bit 13 (64-bit counter), the legacy-route-capable parameter in bit 15, and vendor ID in bits 31:16. Offset 0x004 reads the tick period in femtoseconds.
- R3: The main counter (low word at 0x0F0, high word at 0x0F4) grows by one on every clock edge at which global configuration bit 0 (0x010) is 1. It holds its value while that bit is 0.
- R4: Software writes to the counter words take effect only while bit 0 of 0x010 is 0. While it is 1 they are ignored.
- R5: A one-shot channel fires when it sees the counter equal to its comparator while the unit is enabled. Its output rises one cycle after that match cycle. In edge mode the output is a pulse one clock wide.
- R6: Channel n's config word sits at 0x100+0x20·n. In that word, bit 1 = level (1) or edge (0), bit 2 = interrupt enable, bit 3 = periodic. When a level-mode channel fires, it sets bit n of the status register at 0x020. An edge-mode channel leaves that bit at 0.
- R7: Writing 1 to a status bit clears it, and a level interrupt output falls in the same cycle. Writing 0 leaves the bit unchanged.
- R8: A write to the comparator (low word +0x8, high word +0xC) also loads the channel's period. In periodic mode every firing adds the period to the comparator, so the channel fires every period cycles.
- R9: With its interrupt enable at 0, a channel drives no interrupt. A level-mode channel still sets its status bit.
- R10: Only 32-bit accesses (size code 2) with address bits 1:0 equal to 0 are accepted. Any other access writes nothing, and a read of that kind returns 0.
- R11: The routing mask at +0x4 is read-only and returns the route-mask parameter. The message value (+0x10) and message address (+0x14) words read back what was last written.
- R12: Bit 1 of 0x010 is stored and reads back. It has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| acc_addr | input | 12 | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after the read |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
A read presented before edge E returns its data after edge E, so the bench samples `acc_rdata` at the falling edge that follows. A write takes effect at the edge that captures it. If the enable is captured at edge E0 and the comparator holds C, the counter equals C just after edge E0+C. The interrupt therefore appears after edge E0+C+1, and the bench counts falling edges from the enable write to look at exactly that cycle, one cycle earlier and, for pulses, one cycle later. The value of a counter read is worked out from the number of edges at which the enable bit was 1.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    localparam logic [ADDR_W-1:0] OFS_CAP    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TICK   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_GCFG   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_GSTS   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h0F4;

    localparam int CH_PAGE0 = 8;

    localparam logic [4:0] SUB_CFG   = 5'h00;
    localparam logic [4:0] SUB_ROUTE = 5'h04;
    localparam logic [4:0] SUB_CMPLO = 5'h08;
    localparam logic [4:0] SUB_CMPHI = 5'h0C;
    localparam logic [4:0] SUB_MVAL  = 5'h10;
    localparam logic [4:0] SUB_MADDR = 5'h14;

    typedef struct packed {
        logic periodic;
        logic int_en;
        logic level;
    } ch_cfg_t;

    typedef struct packed {
        logic legacy;
        logic run;
    } gcfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic acc_legal(input logic [1:0] size, input logic [ADDR_W-1:0] addr);
        return (acc_size_e'(size) == SZ_WORD) && (addr[1:0] == 2'b00);
    endfunction

    function automatic logic [DATA_W-1:0] cap_word(input logic [7:0] rev,
                                                   input logic [4:0] last_ch,
                                                   input logic       legacy_cap,
                                                   input logic [15:0] vendor);
        return {vendor, legacy_cap, 1'b0, 1'b1, last_ch, rev};
    endfunction

endpackage

// File: rtl/evt_bus_front.sv
module evt_bus_front
    import evt_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req,
    output logic              rd_any
);
    logic legal;

    always_comb begin
        legal    = acc_legal(size, addr);
        req.wr   = valid & write & legal;
        req.rd   = valid & ~write & legal;
        req.addr = addr;
        req.data = wdata;
        rd_any   = valid & ~write;
    end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] ld_data,
    output logic [CNT_W-1:0]  cnt
);
    localparam int HALF = CNT_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end else begin
            if (ld_lo) cnt[HALF-1:0]     <= ld_data;
            if (ld_hi) cnt[CNT_W-1:HALF] <= ld_data;
        end
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int                IDX        = 0,
    parameter logic [DATA_W-1:0] ROUTE_MASK = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  cnt,
    input  bus_req_t          req,
    input  logic              sts_clr,
    output logic              irq,
    output logic              sts,
    output logic              hit,
    output ch_cfg_t           cfg,
    output logic              cmp_wr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int         HALF = CNT_W / 2;
    localparam logic [6:0] PAGE = 7'(CH_PAGE0 + IDX);

    logic             sel;
    logic [4:0]       sub;
    logic             wr_cfg, wr_lo, wr_hi, wr_mval, wr_maddr;
    logic [CNT_W-1:0] cmp_q, cmp_nxt, per_q;
    logic [DATA_W-1:0] mval_q, maddr_q;
    logic             pulse_q;

    always_comb begin
        sel      = (req.addr[11:5] == PAGE);
        sub      = req.addr[4:0];
        wr_cfg   = req.wr & sel & (sub == SUB_CFG);
        wr_lo    = req.wr & sel & (sub == SUB_CMPLO);
        wr_hi    = req.wr & sel & (sub == SUB_CMPHI);
        wr_mval  = req.wr & sel & (sub == SUB_MVAL);
        wr_maddr = req.wr & sel & (sub == SUB_MADDR);
        cmp_wr   = wr_lo | wr_hi;
        hit      = run & (cnt == cmp_q);
    end

    always_comb begin
        cmp_nxt = cmp_q;
        if (hit && cfg.periodic) cmp_nxt = cmp_q + per_q;
        if (wr_lo) cmp_nxt[HALF-1:0]     = req.data;
        if (wr_hi) cmp_nxt[CNT_W-1:HALF] = req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cmp_q   <= '1;
            per_q   <= '0;
            mval_q  <= '0;
            maddr_q <= '0;
            sts     <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cmp_q <= cmp_nxt;
            if (wr_cfg)   cfg                   <= ch_cfg_t'(req.data[3:1]);
            if (wr_lo)    per_q[HALF-1:0]       <= req.data;
            if (wr_hi)    per_q[CNT_W-1:HALF]   <= req.data;
            if (wr_mval)  mval_q                <= req.data;
            if (wr_maddr) maddr_q               <= req.data;
            if (hit && cfg.level) sts <= 1'b1;
            else if (sts_clr)     sts <= 1'b0;
            pulse_q <= hit & ~cfg.level & cfg.int_en;
        end
    end

    assign irq = (cfg.level & cfg.int_en & sts) | pulse_q;

    always_comb begin
        rd_data = '0;
        if (sel) begin
            case (sub)
                SUB_CFG:   rd_data = {28'd0, cfg, 1'b0};
                SUB_ROUTE: rd_data = ROUTE_MASK;
                SUB_CMPLO: rd_data = cmp_q[HALF-1:0];
                SUB_CMPHI: rd_data = cmp_q[CNT_W-1:HALF];
                SUB_MVAL:  rd_data = mval_q;
                SUB_MADDR: rd_data = maddr_q;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
    import evt_pkg::*;
#(
    parameter int                NUM_CH     = 3,
    parameter logic [7:0]        REV_ID     = 8'h01,
    parameter logic [15:0]       VENDOR_ID  = 16'h5A17,
    parameter logic [DATA_W-1:0] TICK_FS    = 32'd4_000_000,
    parameter logic              LEGACY_CAP = 1'b0,
    parameter logic [DATA_W-1:0] ROUTE_MASK = 32'h00F0_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [11:0]       acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [4:0]        LAST_CH = 5'(NUM_CH - 1);
    localparam logic [DATA_W-1:0] CAP     = cap_word(REV_ID, LAST_CH, LEGACY_CAP, VENDOR_ID);

    bus_req_t         req;
    logic             rd_any;
    gcfg_t            gcfg_q;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic             cnt_ld_lo, cnt_ld_hi, cnt_wr, sts_wr;
    logic [NUM_CH-1:0] ch_sts, ch_hit, ch_level, ch_periodic, ch_ie, ch_cmp_wr, sts_clr;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    logic [DATA_W-1:0] rd_or, rd_mux, rdata_q;

    evt_bus_front u_front (
        .valid (acc_valid),
        .write (acc_write),
        .size  (acc_size),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .req   (req),
        .rd_any(rd_any)
    );

    assign run       = gcfg_q.run;
    assign cnt_ld_lo = req.wr & (req.addr == OFS_CNT_LO) & ~run;
    assign cnt_ld_hi = req.wr & (req.addr == OFS_CNT_HI) & ~run;
    assign cnt_wr    = cnt_ld_lo | cnt_ld_hi;
    assign sts_wr    = req.wr & (req.addr == OFS_GSTS);
    assign sts_clr   = {NUM_CH{sts_wr}} & req.data[NUM_CH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q <= '0;
        end else if (req.wr && req.addr == OFS_GCFG) begin
            gcfg_q <= gcfg_t'(req.data[1:0]);
        end
    end

    evt_main_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .ld_lo  (cnt_ld_lo),
        .ld_hi  (cnt_ld_hi),
        .ld_data(req.data),
        .cnt    (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_cfg_t cfg_g;

        evt_channel #(
            .IDX       (g),
            .ROUTE_MASK(ROUTE_MASK)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .cnt    (cnt),
            .req    (req),
            .sts_clr(sts_clr[g]),
            .irq    (irq[g]),
            .sts    (ch_sts[g]),
            .hit    (ch_hit[g]),
            .cfg    (cfg_g),
            .cmp_wr (ch_cmp_wr[g]),
            .rd_data(ch_rd[g])
        );

        assign ch_level[g]    = cfg_g.level;
        assign ch_periodic[g] = cfg_g.periodic;
        assign ch_ie[g]       = cfg_g.int_en;
    end

    always_comb begin
        rd_or = '0;
        for (int i = 0; i < NUM_CH; i++) rd_or = rd_or | ch_rd[i];
    end

    always_comb begin
        case (req.addr)
            OFS_CAP:    rd_mux = CAP;
            OFS_TICK:   rd_mux = TICK_FS;
            OFS_GCFG:   rd_mux = {30'd0, gcfg_q};
            OFS_GSTS:   rd_mux = DATA_W'(ch_sts);
            OFS_CNT_LO: rd_mux = cnt[31:0];
            OFS_CNT_HI: rd_mux = cnt[63:32];
            default:    rd_mux = rd_or;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            rdata_q <= req.rd ? rd_mux : '0;
        end
    end

    assign acc_rdata = rdata_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_size,
    input logic [11:0]       acc_addr,
    input logic [31:0]       acc_rdata,
    input logic              run,
    input logic [63:0]       cnt,
    input logic              cnt_wr,
    input logic [NUM_CH-1:0] ch_hit,
    input logic [NUM_CH-1:0] ch_level,
    input logic [NUM_CH-1:0] ch_periodic,
    input logic [NUM_CH-1:0] ch_ie,
    input logic [NUM_CH-1:0] ch_cmp_wr,
    input logic [NUM_CH-1:0] ch_sts,
    input logic [NUM_CH-1:0] sts_clr,
    input logic [NUM_CH-1:0] irq
);
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        run |=> cnt == $past(cnt) + 64'd1)
        else $error("counter did not step while enabled");

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt))
        else $error("counter moved while disabled");

    p_rd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && !(acc_size == 2'd2 && acc_addr[1:0] == 2'b00))
        |=> acc_rdata == 32'd0)
        else $error("illegal read returned data");

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        p_sts_src_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_sts[i]) |-> $past(ch_hit[i] && ch_level[i]))
            else $error("status bit set without a level firing");

        p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
            (sts_clr[i] && !(ch_hit[i] && ch_level[i])) |=> !ch_sts[i])
            else $error("status bit survived a clear");

        p_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
            (ch_hit[i] && !ch_periodic[i] && !ch_cmp_wr[i]) |=> !ch_hit[i])
            else $error("one-shot channel matched twice in a row");

        p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
            (!ch_ie[i] && !$past(ch_ie[i])) |-> !irq[i])
            else $error("interrupt without enable");
    end
endmodule

bind evt_timer_unit evt_timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_size   (acc_size),
    .acc_addr   (acc_addr),
    .acc_rdata  (acc_rdata),
    .run        (run),
    .cnt        (cnt),
    .cnt_wr     (cnt_wr),
    .ch_hit     (ch_hit),
    .ch_level   (ch_level),
    .ch_periodic(ch_periodic),
    .ch_ie      (ch_ie),
    .ch_cmp_wr  (ch_cmp_wr),
    .ch_sts     (ch_sts),
    .sts_clr    (sts_clr),
    .irq        (irq)
);

// File: tb/tb_evt_timer_unit.sv
`timescale 1ns/1ps
module tb_evt_timer_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size  = 2'd2;
    logic [11:0] acc_addr  = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [2:0]  irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    evt_timer_unit dut (
        .clk      (clk),
        .rst      (rst),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_size (acc_size),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata),
        .irq      (irq)
    );

    // {req number, address, size code, expected read data}
    localparam logic [49:0] VEC [12] = '{
        {4'd2,  12'h000, 2'd2, 32'h5A17_2201}, // R2 capability
        {4'd2,  12'h004, 2'd2, 32'h003D_0900}, // R2 tick period
        {4'd1,  12'h010, 2'd2, 32'h0000_0000}, // R1 global config
        {4'd1,  12'h020, 2'd2, 32'h0000_0000}, // R1 status
        {4'd1,  12'h0F0, 2'd2, 32'h0000_0000}, // R1 counter low
        {4'd1,  12'h0F4, 2'd2, 32'h0000_0000}, // R1 counter high
        {4'd1,  12'h100, 2'd2, 32'h0000_0000}, // R1 channel config
        {4'd11, 12'h124, 2'd2, 32'h00F0_0000}, // R11 routing mask
        {4'd1,  12'h148, 2'd2, 32'hFFFF_FFFF}, // R1 comparator
        {4'd10, 12'h003, 2'd2, 32'h0000_0000}, // R10 misaligned
        {4'd10, 12'h000, 2'd0, 32'h0000_0000}, // R10 byte size
        {4'd10, 12'h004, 2'd3, 32'h0000_0000}  // R10 double size
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_size = 2'd2;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0; acc_size = 2'd2;
        d = acc_rdata;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", 64'(irq), 64'd0);

        for (int i = 0; i < 12; i++) begin
            rd(VEC[i][45:34], v, VEC[i][33:32]);
            check($sformatf("R%0d vector %0d", VEC[i][49:46], i), 64'(v), 64'(VEC[i][31:0]));
        end

        // R4 load while disabled, R3 counting window
        wr(12'h0F0, 32'd100);
        rd(12'h0F0, v); check("R4 load while disabled", 64'(v), 64'd100);
        wr(12'h010, 32'd1);
        repeat (9) @(negedge clk);
        wr(12'h010, 32'd0);
        rd(12'h0F0, v); check("R3 ten enabled edges", 64'(v), 64'd110);
        repeat (5) @(negedge clk);
        rd(12'h0F0, v); check("R3 frozen while disabled", 64'(v), 64'd110);
        wr(12'h0F0, 32'd0);
        wr(12'h010, 32'd1);
        wr(12'h0F0, 32'd500);
        wr(12'h010, 32'd0);
        rd(12'h0F0, v); check("R4 write ignored while running", 64'(v), 64'd2);
        wr(12'h0F4, 32'd1);
        rd(12'h0F4, v); check("R4 high word load", 64'(v), 64'd1);
        wr(12'h0F4, 32'd0);

        // R5 R6 R7 one-shot level channel 0
        wr(12'h0F0, 32'd0);
        wr(12'h108, 32'd20); wr(12'h10C, 32'd0);
        wr(12'h100, 32'h6);
        wr(12'h010, 32'd1);
        repeat (20) @(negedge clk);
        check("R5 level irq not yet", 64'(irq[0]), 64'd0);
        @(negedge clk);
        check("R5 level irq due", 64'(irq[0]), 64'd1);
        rd(12'h020, v); check("R6 level status set", 64'(v), 64'h1);
        wr(12'h020, 32'd0);
        check("R7 write zero keeps irq", 64'(irq[0]), 64'd1);
        wr(12'h020, 32'd1);
        check("R7 write one drops irq", 64'(irq[0]), 64'd0);
        rd(12'h020, v); check("R7 status cleared", 64'(v), 64'h0);
        wr(12'h010, 32'd0); wr(12'h100, 32'h0);

        // R5 R6 edge channel 1
        wr(12'h0F0, 32'd0);
        wr(12'h128, 32'd10); wr(12'h12C, 32'd0);
        wr(12'h120, 32'h4);
        wr(12'h010, 32'd1);
        repeat (10) @(negedge clk);
        check("R5 edge pulse not yet", 64'(irq[1]), 64'd0);
        @(negedge clk);
        check("R5 edge pulse high", 64'(irq[1]), 64'd1);
        @(negedge clk);
        check("R5 edge pulse one clock", 64'(irq[1]), 64'd0);
        rd(12'h020, v); check("R6 edge leaves status 0", 64'(v), 64'h0);
        wr(12'h010, 32'd0); wr(12'h120, 32'h0);

        // R8 periodic edge channel 2, period 5
        wr(12'h0F0, 32'd0);
        wr(12'h148, 32'd5); wr(12'h14C, 32'd0);
        wr(12'h140, 32'hC);
        wr(12'h010, 32'd1);
        repeat (6) @(negedge clk);
        check("R8 first firing", 64'(irq[2]), 64'd1);
        @(negedge clk);
        check("R8 quiet between", 64'(irq[2]), 64'd0);
        repeat (4) @(negedge clk);
        check("R8 second firing", 64'(irq[2]), 64'd1);
        repeat (5) @(negedge clk);
        check("R8 third firing", 64'(irq[2]), 64'd1);
        wr(12'h010, 32'd0);
        rd(12'h148, v); check("R8 comparator advanced", 64'(v), 64'd20);
        wr(12'h140, 32'h0);

        // R9 level without interrupt enable
        wr(12'h0F0, 32'd0);
        wr(12'h108, 32'd3);
        wr(12'h100, 32'h2);
        wr(12'h010, 32'd1);
        repeat (6) @(negedge clk);
        check("R9 no irq when disabled", 64'(irq[0]), 64'd0);
        rd(12'h020, v); check("R9 status still set", 64'(v), 64'h1);
        wr(12'h010, 32'd0); wr(12'h020, 32'h7); wr(12'h100, 32'h0);

        // R11 storage words and read-only mask
        wr(12'h130, 32'hA5A5_0F0F);
        rd(12'h130, v); check("R11 message value", 64'(v), 64'hA5A5_0F0F);
        wr(12'h134, 32'h1234_5678);
        rd(12'h134, v); check("R11 message address", 64'(v), 64'h1234_5678);
        wr(12'h104, 32'd0);
        rd(12'h104, v); check("R11 mask read-only", 64'(v), 64'h00F0_0000);

        // R12 legacy bit stored, counter idle
        wr(12'h0F0, 32'd7);
        wr(12'h010, 32'h2);
        rd(12'h010, v); check("R12 legacy bit reads back", 64'(v), 64'h2);
        repeat (4) @(negedge clk);
        rd(12'h0F0, v); check("R12 counter not running", 64'(v), 64'd7);
        wr(12'h010, 32'h0);

        // R10 illegal writes
        wr(12'h011, 32'h1);
        wr(12'h010, 32'h1, 2'd0);
        rd(12'h010, v); check("R10 illegal writes ignored", 64'(v), 64'h0);
        rd(12'h0F0, v); check("R10 counter still idle", 64'(v), 64'd7);

        // R1 reset in mid operation
        wr(12'h0F0, 32'd0);
        wr(12'h108, 32'd2);
        wr(12'h100, 32'h6);
        wr(12'h010, 32'd1);
        repeat (5) @(negedge clk);
        check("R5 level irq before reset", 64'(irq[0]), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq cleared by reset", 64'(irq), 64'd0);
        rd(12'h0F0, v); check("R1 counter reset", 64'(v), 64'd0);
        rd(12'h010, v); check("R1 config reset", 64'(v), 64'd0);
        rd(12'h108, v); check("R1 comparator reset", 64'(v), 64'hFFFF_FFFF);
        rd(12'h020, v); check("R1 status reset", 64'(v), 64'd0);

        done = 1;
        report();
    end
endmodule